// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block is a hardware state machine that brings the analog sections of an I/O PHY up in a fixed order. It has two request inputs, one to power on and one to power off. It drives the PHY's power-down-bar (`pdb_o`) and DLL-enable (`dll_en_o`) controls. It reads the calibration-done and DLL-ready status lines once each, at fixed points in the sequence. It reports the result on `busy_o`, a one-cycle `done_o` pulse, or an error flag with a code that names the stage that failed.

Each wait is a minimum time in nanoseconds, converted to a cycle count from the `CLK_MHZ` parameter. A power-off request completes as soon as both controls are low. A power-on request runs through four steps:

1. It holds both controls low while the pad calibration logic initialises.
2. It raises power-down-bar and waits for pad trimming to finish.
3. It checks calibration, then raises DLL-enable and waits for the DLL to lock.
4. It checks DLL-ready.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, `pdb_o`, `dll_en_o`, `busy_o`, `done_o` and `err_o` are 0 and `err_code_o` is 2'b00.
- R2: A request is accepted only when `busy_o` is low. In the cycle after acceptance, `pdb_o` and `dll_en_o` are 0 and `err_o` and `err_code_o` are cleared. This holds even when a previous sequence left the controls high.
- R3: An accepted power-off request gives `done_o` = 1 in the next cycle, with `busy_o` = 0 and both controls low.
- R4: For an accepted power-on request, `busy_o` rises in the next cycle. `pdb_o` stays 0 for exactly INIT = ceil(INIT_NS*CLK_MHZ/1000) cycles after the accepting edge and then rises. INIT is 750 at 250 MHz.
- R5: `cal_done_i` is sampled once, TRIM = ceil(TRIM_NS*CLK_MHZ/1000) cycles after `pdb_o` rises. TRIM is 1250 at 250 MHz. If it is 1, `dll_en_o` rises at that edge and `busy_o` stays high. A calibration-done that arrives later than that sample does not count.
- R6: If `cal_done_i` is 0 at its sample, the sequence ends with `err_o` = 1, `err_code_o` = 2'b01 (calibration timeout) and `busy_o` = 0. `pdb_o` stays 1 and `dll_en_o` stays 0.
- R7: `dll_rdy_i` is sampled once, LOCK = ceil(LOCK_NS*CLK_MHZ/1000) cycles after `dll_en_o` rises. LOCK is 2750 at 250 MHz. If it is 1, `done_o` pulses and `busy_o` falls, while both controls stay high.
- R8: If `dll_rdy_i` is 0 at its sample, the sequence ends with `err_o` = 1, `err_code_o` = 2'b10 (DLL timeout) and `busy_o` = 0. Both controls stay high and `done_o` stays 0.
- R9: Requests of either kind that arrive while `busy_o` is high are ignored, and the running sequence keeps its timing.
- R10: If both requests are high together while idle, power-off is taken.
- R11: `done_o` lasts exactly one cycle. `err_o` and `err_code_o` hold their values until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_on_req_i | input | 1 | Power-on request |
| pwr_off_req_i | input | 1 | Power-off request |
| cal_done_i | input | 1 | PHY calibration-done status |
| dll_rdy_i | input | 1 | PHY DLL-ready status |
| pdb_o | output | 1 | PHY power-down-bar control |
| dll_en_o | output | 1 | PHY DLL-enable control |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | Sequence ended in a timeout |
| err_code_o | output | 2 | 01 calibration timeout, 10 DLL timeout, 00 none |

## Verification
A wrong state or a wrong wait count shows up at the ports as an edge of `pdb_o` or `dll_en_o` that is one cycle early or late. For that reason, the bench checks every control edge in the cycle before it is due and again in the cycle it is due.

A status line sampled at the wrong moment shows as a wrong outcome in the boundary cases. The model PHY asserts its status either exactly at the sampling edge or one cycle after it, so the error codes appear, or fail to appear, at the end of the sequence.

A missing busy guard disturbs the control timing within one cycle of a request injected mid-sequence.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_TRIM,
    ST_LOCK
  } seq_state_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_CAL  = 2'b01,
    ERR_DLL  = 2'b10
  } seq_err_e;

  // minimum time in ns -> cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             exp_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign exp_o = (cnt_q == '0);

  assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_pwr_seq_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int INIT_CYC = 750,
  parameter int TRIM_CYC = 1250,
  parameter int LOCK_CYC = 2750
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             on_req_i,
  input  logic             off_req_i,
  input  logic             cal_done_i,
  input  logic             dll_rdy_i,
  input  logic             tmr_exp_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_len_o,
  output logic             pdb_o,
  output logic             dll_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [1:0]       err_code_o
);

  localparam logic [CNT_W-1:0] INIT_LEN = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] TRIM_LEN = CNT_W'(TRIM_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LEN = CNT_W'(LOCK_CYC - 1);

  seq_state_e state_q;
  seq_err_e   code_q;
  logic       pdb_q, dll_q, busy_q, done_q, err_q;
  logic       take_on, take_off;

  assign take_off = (state_q == ST_IDLE) && off_req_i;
  assign take_on  = (state_q == ST_IDLE) && on_req_i && !off_req_i;

  always_comb begin
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    unique case (state_q)
      ST_IDLE: if (take_on) begin
        tmr_load_o = 1'b1;
        tmr_len_o  = INIT_LEN;
      end
      ST_INIT: if (tmr_exp_i) begin
        tmr_load_o = 1'b1;
        tmr_len_o  = TRIM_LEN;
      end
      ST_TRIM: if (tmr_exp_i && cal_done_i) begin
        tmr_load_o = 1'b1;
        tmr_len_o  = LOCK_LEN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= ERR_NONE;
      pdb_q   <= 1'b0;
      dll_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_off || take_on) begin
            pdb_q  <= 1'b0;
            dll_q  <= 1'b0;
            err_q  <= 1'b0;
            code_q <= ERR_NONE;
          end
          if (take_off) done_q <= 1'b1;
          if (take_on) begin
            busy_q  <= 1'b1;
            state_q <= ST_INIT;
          end
        end
        ST_INIT: if (tmr_exp_i) begin
          pdb_q   <= 1'b1;
          state_q <= ST_TRIM;
        end
        ST_TRIM: if (tmr_exp_i) begin
          if (cal_done_i) begin
            dll_q   <= 1'b1;
            state_q <= ST_LOCK;
          end else begin
            err_q   <= 1'b1;
            code_q  <= ERR_CAL;
            busy_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_LOCK: if (tmr_exp_i) begin
          busy_q  <= 1'b0;
          state_q <= ST_IDLE;
          if (dll_rdy_i) begin
            done_q <= 1'b1;
          end else begin
            err_q  <= 1'b1;
            code_q <= ERR_DLL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pdb_o      = pdb_q;
  assign dll_en_o   = dll_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign err_code_o = code_q;

  assert_accept_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && (on_req_i || off_req_i)) |=> (!pdb_o && !dll_en_o && !err_o));

  assert_dll_after_pdb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dll_en_o |-> pdb_o);

  assert_err_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o != 2'b00));

  assert_done_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !err_o));

  assert_busy_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tmr_exp_i) |=> (busy_o && $stable(pdb_o) && $stable(dll_en_o)));

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_seq_pkg::*;
#(
  parameter int CLK_MHZ = 250,
  parameter int INIT_NS = 3000,
  parameter int TRIM_NS = 5000,
  parameter int LOCK_NS = 11000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_on_req_i,
  input  logic       pwr_off_req_i,
  input  logic       cal_done_i,
  input  logic       dll_rdy_i,
  output logic       pdb_o,
  output logic       dll_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [1:0] err_code_o
);

  localparam int INIT_CYC = ns_to_cyc(INIT_NS, CLK_MHZ);
  localparam int TRIM_CYC = ns_to_cyc(TRIM_NS, CLK_MHZ);
  localparam int LOCK_CYC = ns_to_cyc(LOCK_NS, CLK_MHZ);
  localparam int MAX_CYC  = (INIT_CYC > TRIM_CYC) ?
                            ((INIT_CYC > LOCK_CYC) ? INIT_CYC : LOCK_CYC) :
                            ((TRIM_CYC > LOCK_CYC) ? TRIM_CYC : LOCK_CYC);
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic             tmr_load, tmr_exp;
  logic [CNT_W-1:0] tmr_len;

  phy_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .len_i  (tmr_len),
    .exp_o  (tmr_exp)
  );

  phy_seq_ctrl #(
    .CNT_W    (CNT_W),
    .INIT_CYC (INIT_CYC),
    .TRIM_CYC (TRIM_CYC),
    .LOCK_CYC (LOCK_CYC)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .on_req_i   (pwr_on_req_i),
    .off_req_i  (pwr_off_req_i),
    .cal_done_i (cal_done_i),
    .dll_rdy_i  (dll_rdy_i),
    .tmr_exp_i  (tmr_exp),
    .tmr_load_o (tmr_load),
    .tmr_len_o  (tmr_len),
    .pdb_o      (pdb_o),
    .dll_en_o   (dll_en_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .err_code_o (err_code_o)
  );

endmodule

// File: tb/tb_phy_pwr_seq.sv
`timescale 1ns/1ps
module tb_phy_pwr_seq;

  localparam int MHZ = 250;
  localparam int T1  = (3000 * MHZ + 999) / 1000;
  localparam int T2  = (5000 * MHZ + 999) / 1000;
  localparam int T3  = (11000 * MHZ + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_req = 1'b0, off_req = 1'b0;
  logic cal_done, dll_rdy;
  logic pdb, dll_en, busy, done, err;
  logic [1:0] code;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int cal_dly = 0, dll_dly = 0;
  int pcnt = 0, dcnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  phy_pwr_seq #(.CLK_MHZ(MHZ)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pwr_on_req_i(on_req), .pwr_off_req_i(off_req),
    .cal_done_i(cal_done), .dll_rdy_i(dll_rdy),
    .pdb_o(pdb), .dll_en_o(dll_en), .busy_o(busy),
    .done_o(done), .err_o(err), .err_code_o(code)
  );

  // analog PHY model: status rises a set number of cycles after its control
  always @(posedge clk) begin
    pcnt <= pdb ? pcnt + 1 : 0;
    dcnt <= dll_en ? dcnt + 1 : 0;
  end
  assign cal_done = pdb && (pcnt >= cal_dly);
  assign dll_rdy  = dll_en && (dcnt >= dll_dly);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset();
    chk("R1", "pdb", pdb, 0);
    chk("R1", "dll_en", dll_en, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    chk("R1", "code", code, 0);
  endtask

  task automatic t_off(input bit both);
    off_req = 1'b1;
    on_req  = both;
    tick(1);
    off_req = 1'b0;
    on_req  = 1'b0;
    chk(both ? "R10" : "R3", "done", done, 1);
    chk(both ? "R10" : "R3", "busy", busy, 0);
    chk("R2", "pdb low", pdb, 0);
    chk("R2", "dll_en low", dll_en, 0);
    chk("R2", "err cleared", err, 0);
    chk("R2", "code cleared", code, 0);
    tick(1);
    chk("R11", "done one cycle", done, 0);
    chk(both ? "R10" : "R3", "busy after", busy, 0);
  endtask

  // inject: hold both requests during the init wait
  task automatic t_on(input int c, input int d, input bit inject);
    cal_dly = c;
    dll_dly = d;
    on_req = 1'b1;
    tick(1);
    on_req = inject;
    off_req = inject;
    chk("R2", "pdb low", pdb, 0);
    chk("R2", "dll_en low", dll_en, 0);
    chk("R2", "err cleared", err, 0);
    chk("R4", "busy", busy, 1);
    tick(T1 - 1);
    chk(inject ? "R9" : "R4", "pdb before INIT", pdb, 0);
    chk(inject ? "R9" : "R4", "busy held", busy, 1);
    tick(1);
    chk(inject ? "R9" : "R4", "pdb at INIT", pdb, 1);
    on_req = 1'b0;
    off_req = 1'b0;
    tick(T2 - 1);
    chk("R5", "dll_en before TRIM", dll_en, 0);
    tick(1);
    if (c > T2 - 1) begin
      chk("R6", "err", err, 1);
      chk("R6", "code", code, 1);
      chk("R6", "busy", busy, 0);
      chk("R6", "pdb held", pdb, 1);
      chk("R6", "dll_en", dll_en, 0);
      tick(20);
      chk("R11", "err held", err, 1);
      chk("R11", "code held", code, 1);
      return;
    end
    chk("R5", "dll_en at TRIM", dll_en, 1);
    chk("R5", "busy", busy, 1);
    tick(T3 - 1);
    chk("R7", "done before LOCK", done, 0);
    chk("R7", "busy before LOCK", busy, 1);
    tick(1);
    chk("R7", "busy at LOCK", busy, 0);
    chk("R7", "pdb high", pdb, 1);
    chk("R7", "dll_en high", dll_en, 1);
    if (d > T3 - 1) begin
      chk("R8", "err", err, 1);
      chk("R8", "code", code, 2);
      chk("R8", "done", done, 0);
      tick(5);
      chk("R11", "err held", err, 1);
      chk("R8", "controls held", {pdb, dll_en}, 3);
    end else begin
      chk("R7", "done", done, 1);
      chk("R7", "err", err, 0);
      tick(1);
      chk("R11", "done one cycle", done, 0);
    end
  endtask

  initial begin
    tick(2);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_off(0);                 // R3 from idle
    t_on(100, 200, 0);        // R4 R5 R7 nominal
    t_on(T2 - 1, T3 - 1, 0);  // R2 restart from on, R5 R7 boundary
    t_off(0);
    t_on(T2, 0, 0);           // R6 calibration one cycle late
    t_off(0);                 // R11 err cleared by request
    t_on(0, T3, 0);           // R8 DLL one cycle late
    t_on(10, 10, 1);          // R9 requests while busy
    tick(3);
    t_off(1);                 // R10 both requests
    summary();
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        summary();
      end
    end
  end

endmodule